// File: doc/BRIEF.md
# Walking-bit memory pattern checker

This block is a built-in self-test engine for a narrow DRAM channel that has already been brought out of initialization. Once started, it sweeps every row address. For each row it writes a 16-byte burst holding a single walking one-bit, reads the same row back, and compares the returned bytes against the burst it wrote. It talks to the memory through a small command port. Each command is held until the port accepts it, so all DRAM timing belongs to the port side.

The write burst is built from a seed byte that holds one set bit. Each byte of the burst is the previous value shifted left by one position, and a value that falls to zero is reloaded with 0x01. The seed advances in the same way from one row to the next. Over a sweep, every data line and every address line sees both polarities.

The engine keeps a saturating count of all mismatching bytes. It also records the first mismatch: the row, the byte lane, the byte read back and the byte expected. When the sweep ends it raises a done flag and reports pass or fail.

Top module: `wb_bist`

## Requirements
- R1: After reset, busy, done, pass, cmd_valid, first_err_valid are 0 and err_count is 0.
- R2: A start pulse while idle or done begins a sweep at row 0. A start pulse while busy has no effect on the command stream.
- R3: For each row the command ops are, in order: activate, completion, write, completion, activate, completion, read, completion. The op encodings are activate=0, write=1, read=2, completion=3.
- R4: A command with cmd_valid high and cmd_ready low stays on the port unchanged in the next cycle, and the next command is issued only after cmd_ready is seen high.
- R5: An activate carries the row number, zero-extended, in cmd_addr. A write or read carries row bits [6:5] in cmd_addr[9:8], with every other bit 0. A completion carries address 0.
- R6: With a write, byte lane i (cmd_wdata[8i+7:8i]) equals the row seed shifted left i+1 times, where a step that gives zero yields 0x01 instead.
- R7: The seed is 0x01 for row 0 and advances per row by the same shift-with-wrap rule.
- R8: Rows are visited in ascending order from 0 to 2^ROW_W-1. After the completion of the last row is accepted, done rises and no further commands are issued.
- R9: Read data is taken on the first cycle rd_valid is high after a read has been accepted. err_count then grows by the number of byte lanes that differ from the pattern, saturating at its maximum.
- R10: On the first mismatch of a sweep, the engine records the row, the lowest mismatching byte lane, the byte read and the byte expected, and sets first_err_valid. Later mismatches in the same sweep do not change this record.
- R11: done is held until the next start. pass is high exactly when done is high and err_count is 0. A new start clears err_count and first_err_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, held until next start |
| pass | output | 1 | Finished with no mismatch |
| cmd_valid | output | 1 | Command present on the port |
| cmd_ready | input | 1 | Port accepts the present command |
| cmd_op | output | 2 | Command op (0 act, 1 write, 2 read, 3 completion) |
| cmd_addr | output | CMD_AW | Command address |
| cmd_wdata | output | NBYTES*8 | Write burst, valid with a write op |
| rd_valid | input | 1 | Read data present |
| rd_data | input | NBYTES*8 | Read burst |
| err_count | output | CNT_W | Mismatching bytes so far |
| first_err_valid | output | 1 | A first mismatch has been recorded |
| first_err_row | output | ROW_W | Row of first mismatch |
| first_err_byte | output | $clog2(NBYTES) | Byte lane of first mismatch |
| first_err_got | output | 8 | Byte read at first mismatch |
| first_err_exp | output | 8 | Byte expected at first mismatch |

## Verification
The assertions assume that the port raises cmd_ready only as a reply to a command actually present. They also assume rd_valid comes after an accepted read and before the engine moves on. Acceptance is taken as the cycle where cmd_valid and cmd_ready are both high. The bench's memory model pulses cmd_ready for a single cycle, and only after it has seen cmd_valid held for a varying 0 to 2 cycles. It returns exactly one rd_valid pulse, two cycles after each accepted read, with the burst from the last write, optionally spoiled by fixed fault masks. The sweep is shortened to 128 rows, so that row bits [6:5] and a full seed wrap are still covered.

// File: rtl/wb_pkg.sv
// Package: shared command encoding for the walking-bit checker.
// Assumes: 2-bit op field on the command port.
package wb_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_WR  = 2'd1,
        OP_RD  = 2'd2,
        OP_CPL = 2'd3
    } wb_op_e;
endpackage

// File: rtl/wb_pattern_gen.sv
// Module: builds the write burst from the row seed by chaining a
// shift-left-with-zero-reload step once per byte lane.
// Assumes: seed is held stable for the whole row.
module wb_pattern_gen #(
    parameter int NBYTES = 16
) (
    input  logic [7:0]          seed,
    output logic [NBYTES*8-1:0] pattern
);
    logic [7:0] chain [NBYTES+1];

    assign chain[0] = seed;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [7:0] shifted;
        // one shift step per lane, zero reloads to 0x01
        assign shifted      = {chain[g][6:0], 1'b0};
        assign chain[g+1]   = (shifted == 8'h00) ? 8'h01 : shifted;
        assign pattern[g*8 +: 8] = chain[g+1];
    end
endmodule

// File: rtl/wb_compare.sv
// Module: compares a read burst with the expected burst per byte lane,
// returns the mismatch count and the lowest mismatching lane.
// Assumes: purely combinational, sampled by the caller.
module wb_compare #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0]         got,
    input  logic [NBYTES*8-1:0]         exp,
    output logic                        any_miss,
    output logic [$clog2(NBYTES)-1:0]   first_idx,
    output logic [$clog2(NBYTES+1)-1:0] miss_cnt
);
    localparam int IDX_W = $clog2(NBYTES);
    localparam int CW    = $clog2(NBYTES+1);

    logic [NBYTES-1:0] miss;

    for (genvar g = 0; g < NBYTES; g++) begin : g_cmp
        assign miss[g] = (got[g*8 +: 8] != exp[g*8 +: 8]);
    end

    // count mismatches and locate the lowest one
    always_comb begin
        miss_cnt  = '0;
        first_idx = '0;
        for (int i = NBYTES - 1; i >= 0; i--) begin
            miss_cnt = miss_cnt + CW'(miss[i]);
            if (miss[i]) first_idx = IDX_W'(i);
        end
    end

    assign any_miss = |miss;
endmodule

// File: rtl/wb_seq.sv
// Module: row sweep and command sequencer. Walks rows in ascending order,
// issues the eight commands of each row, waits on the ready handshake and
// on read data, and advances the seed per row.
// Assumes: ROW_W >= COL_LSB + 2; cmd_ready meaningful only with cmd_valid.
module wb_seq
    import wb_pkg::*;
#(
    parameter int ROW_W     = 15,
    parameter int CMD_AW    = 16,
    parameter int COL_LSB   = 5,
    parameter int COL_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_ready,
    input  logic              rd_valid,
    output logic              cmd_valid,
    output wb_op_e            cmd_op,
    output logic [CMD_AW-1:0] cmd_addr,
    output logic [ROW_W-1:0]  row,
    output logic [7:0]        seed,
    output logic              busy,
    output logic              done,
    output logic              launch,
    output logic              rd_take
);
    typedef enum logic [1:0] {S_IDLE, S_CMD, S_RDWAIT, S_DONE} state_e;

    localparam logic [ROW_W-1:0] LAST_ROW = '1;
    localparam logic [2:0]       STEP_RD  = 3'd6;
    localparam logic [2:0]       STEP_END = 3'd7;

    state_e     state;
    logic [2:0] step;
    logic [7:0] seed_nxt;
    logic       accept;

    assign busy      = (state == S_CMD) || (state == S_RDWAIT);
    assign done      = (state == S_DONE);
    assign cmd_valid = (state == S_CMD);
    assign accept    = cmd_valid && cmd_ready;
    assign launch    = start && !busy;
    assign rd_take   = (state == S_RDWAIT) && rd_valid;

    // seed advance: shift left, zero reloads to 0x01
    always_comb begin
        seed_nxt = {seed[6:0], 1'b0};
        if (seed_nxt == 8'h00) seed_nxt = 8'h01;
    end

    // op and address from the step within the row
    always_comb begin
        if (step[0]) begin
            cmd_op   = OP_CPL;
            cmd_addr = '0;
        end else begin
            unique case (step[2:1])
                2'd0, 2'd2: cmd_op = OP_ACT;
                2'd1:       cmd_op = OP_WR;
                default:    cmd_op = OP_RD;
            endcase
            if (cmd_op == OP_ACT) cmd_addr = CMD_AW'(row);
            else cmd_addr = CMD_AW'(row[COL_LSB+1:COL_LSB]) << COL_SHIFT;
        end
    end

    // state, step, row and seed registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            step  <= '0;
            row   <= '0;
            seed  <= 8'h01;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        state <= S_CMD;
                        step  <= '0;
                        row   <= '0;
                        seed  <= 8'h01;
                    end
                end
                S_CMD: begin
                    if (accept) begin
                        if (step == STEP_RD) begin
                            state <= S_RDWAIT;
                        end else if (step == STEP_END) begin
                            if (row == LAST_ROW) begin
                                state <= S_DONE;
                            end else begin
                                row  <= row + 1'b1;
                                seed <= seed_nxt;
                                step <= '0;
                            end
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                default: begin
                    if (rd_valid) begin
                        state <= S_CMD;
                        step  <= STEP_END;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wb_bist.sv
// Module: top of the walking-bit checker. Ties the sequencer, pattern
// generator and comparator together and keeps the error record.
// Assumes: rd_data valid on the cycle rd_valid is high after a read.
module wb_bist
    import wb_pkg::*;
#(
    parameter int ROW_W     = 15,
    parameter int NBYTES    = 16,
    parameter int CMD_AW    = 16,
    parameter int COL_LSB   = 5,
    parameter int COL_SHIFT = 8,
    parameter int CNT_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic                      busy,
    output logic                      done,
    output logic                      pass,
    output logic                      cmd_valid,
    input  logic                      cmd_ready,
    output logic [1:0]                cmd_op,
    output logic [CMD_AW-1:0]         cmd_addr,
    output logic [NBYTES*8-1:0]       cmd_wdata,
    input  logic                      rd_valid,
    input  logic [NBYTES*8-1:0]       rd_data,
    output logic [CNT_W-1:0]          err_count,
    output logic                      first_err_valid,
    output logic [ROW_W-1:0]          first_err_row,
    output logic [$clog2(NBYTES)-1:0] first_err_byte,
    output logic [7:0]                first_err_got,
    output logic [7:0]                first_err_exp
);
    localparam int IDX_W = $clog2(NBYTES);
    localparam int CW    = $clog2(NBYTES+1);

    wb_op_e             op_e;
    logic [ROW_W-1:0]   row;
    logic [7:0]         seed;
    logic               launch;
    logic               rd_take;
    logic [NBYTES*8-1:0] pattern;
    logic               any_miss;
    logic [IDX_W-1:0]   first_idx;
    logic [CW-1:0]      miss_cnt;
    logic [CNT_W:0]     sum;

    wb_seq #(
        .ROW_W(ROW_W), .CMD_AW(CMD_AW),
        .COL_LSB(COL_LSB), .COL_SHIFT(COL_SHIFT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_ready(cmd_ready), .rd_valid(rd_valid),
        .cmd_valid(cmd_valid), .cmd_op(op_e), .cmd_addr(cmd_addr),
        .row(row), .seed(seed), .busy(busy), .done(done),
        .launch(launch), .rd_take(rd_take)
    );

    wb_pattern_gen #(.NBYTES(NBYTES)) u_pat (
        .seed(seed), .pattern(pattern)
    );

    wb_compare #(.NBYTES(NBYTES)) u_cmp (
        .got(rd_data), .exp(pattern), .any_miss(any_miss),
        .first_idx(first_idx), .miss_cnt(miss_cnt)
    );

    assign cmd_op    = op_e;
    assign cmd_wdata = pattern;
    assign pass      = done && (err_count == '0);
    assign sum       = {1'b0, err_count} + (CNT_W+1)'(miss_cnt);

    // error counter and first-mismatch record
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            err_count       <= '0;
            first_err_valid <= 1'b0;
            first_err_row   <= '0;
            first_err_byte  <= '0;
            first_err_got   <= '0;
            first_err_exp   <= '0;
        end else if (rd_take) begin
            err_count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            if (any_miss && !first_err_valid) begin
                first_err_valid <= 1'b1;
                first_err_row   <= row;
                first_err_byte  <= first_idx;
                first_err_got   <= rd_data[first_idx*8 +: 8];
                first_err_exp   <= pattern[first_idx*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/wb_bist_chk.sv
// Module: protocol and record checks for wb_bist, bound to every instance.
// Assumes: cmd_ready is only a reply to a present command.
module wb_bist_chk #(
    parameter int CMD_AW = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic [CMD_AW-1:0] cmd_addr,
    input logic [CNT_W-1:0]  err_count,
    input logic              first_err_valid
);
    logic [1:0] last_op;

    // op of the last accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) last_op <= 2'd3;
        else if (cmd_valid && cmd_ready) last_op <= cmd_op;
    end

    a_r4_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));

    a_r3_cpl_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && last_op != 2'd3 |-> cmd_op == 2'd3);

    a_r3_no_double_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && last_op == 2'd3 |-> cmd_op != 2'd3);

    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    a_r8_done_after_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd3));

    a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r9_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> err_count >= $past(err_count));

    a_r10_record_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        first_err_valid |-> err_count != '0);
endmodule

bind wb_bist wb_bist_chk #(.CMD_AW(CMD_AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .err_count(err_count),
    .first_err_valid(first_err_valid)
);

// File: tb/sim_wb_bist.sv
module sim_wb_bist;
    localparam int ROW_W  = 7;
    localparam int NB     = 16;
    localparam int AW     = 16;
    localparam int CNT_W  = 16;
    localparam int NROWS  = 1 << ROW_W;

    typedef struct {
        logic [1:0]     op;
        logic [AW-1:0]  addr;
        logic [NB*8-1:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, start, cmd_ready, rd_valid;
    logic busy, done, pass, cmd_valid, first_err_valid;
    logic [1:0] cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [NB*8-1:0] cmd_wdata, rd_data;
    logic [CNT_W-1:0] err_count;
    logic [ROW_W-1:0] first_err_row;
    logic [3:0] first_err_byte;
    logic [7:0] first_err_got, first_err_exp;

    int nchk = 0, nfail = 0;
    exp_t q[$];
    bit fault_en = 0;
    bit seen = 0;
    logic [1:0] h_op;
    logic [AW-1:0] h_addr;
    int wcnt = 0, dcnt = 0, rd_cnt = 0;
    logic [ROW_W-1:0] act_row = '0;
    logic [NB*8-1:0] last_wr = '0;

    always #2 clk = ~clk;

    wb_bist #(.ROW_W(ROW_W), .NBYTES(NB), .CMD_AW(AW), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_count(err_count),
        .first_err_valid(first_err_valid), .first_err_row(first_err_row),
        .first_err_byte(first_err_byte), .first_err_got(first_err_got),
        .first_err_exp(first_err_exp)
    );

    function automatic logic [7:0] step8(input logic [7:0] v);
        logic [7:0] s = {v[6:0], 1'b0};
        return (s == 8'h00) ? 8'h01 : s;
    endfunction

    // expected burst for a row (R6, R7)
    function automatic logic [NB*8-1:0] exp_pat(input int r);
        logic [7:0] sd = 8'h01;
        logic [7:0] d;
        logic [NB*8-1:0] p;
        for (int j = 0; j < r; j++) sd = step8(sd);
        d = sd;
        for (int i = 0; i < NB; i++) begin
            d = step8(d);
            p[i*8 +: 8] = d;
        end
        return p;
    endfunction

    function automatic logic [NB*8-1:0] fault(input int r);
        logic [NB*8-1:0] m = '0;
        if (fault_en && r == 9) m[3*8 +: 8] = 8'h10;
        if (fault_en && r == 40) begin
            m[0 +: 8]    = 8'hFF;
            m[15*8 +: 8] = 8'h01;
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: push the expected command stream of one sweep (R3, R5, R6)
    task automatic push_run();
        for (int r = 0; r < NROWS; r++) begin
            logic [AW-1:0] col = AW'(((r >> 5) & 3) << 8);
            q.push_back('{2'd0, AW'(r), '0});
            q.push_back('{2'd3, '0, '0});
            q.push_back('{2'd1, col, exp_pat(r)});
            q.push_back('{2'd3, '0, '0});
            q.push_back('{2'd0, AW'(r), '0});
            q.push_back('{2'd3, '0, '0});
            q.push_back('{2'd2, col, '0});
            q.push_back('{2'd3, '0, '0});
        end
    endtask

    // monitor: pop and compare one accepted command
    task automatic accept_cmd();
        exp_t e;
        if (q.size() == 0) begin
            chk(0, "R8 extra command", NB*8'(cmd_op), 0);
            return;
        end
        e = q.pop_front();
        chk(cmd_op == e.op, "R3 op order", NB*8'(cmd_op), NB*8'(e.op));
        chk(cmd_addr == e.addr, "R5 address", NB*8'(cmd_addr), NB*8'(e.addr));
        if (e.op == 2'd1) chk(cmd_wdata == e.data, "R6/R7 write burst", cmd_wdata, e.data);
        if (cmd_op == 2'd0) act_row = cmd_addr[ROW_W-1:0];
        if (cmd_op == 2'd1) last_wr = cmd_wdata;
        if (cmd_op == 2'd2) rd_cnt = 2;
    endtask

    // memory model: ready handshake with varying latency, read return
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_ready = 0; rd_valid = 0; seen = 0; rd_cnt = 0;
        end else begin
            if (rd_valid) rd_valid = 0;
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    rd_valid = 1;
                    rd_data  = last_wr ^ fault(int'(act_row));
                end
            end
            if (cmd_ready) begin
                cmd_ready = 0;
                seen = 0;
            end else if (cmd_valid) begin
                if (!seen) begin
                    seen = 1; h_op = cmd_op; h_addr = cmd_addr;
                    wcnt = dcnt % 3; dcnt++;
                end else begin
                    chk(cmd_op == h_op && cmd_addr == h_addr, "R4 held command",
                        NB*8'({cmd_op, cmd_addr}), NB*8'({h_op, h_addr}));
                end
                if (wcnt == 0) begin
                    cmd_ready = 1;
                    accept_cmd();
                end else wcnt--;
            end
        end
    end

    task automatic pulse_start();
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk(0, "R8 watchdog expired", 0, 1);
    endtask

    initial begin
        #(200000 * 4);
        nchk++; nfail++;
        $display("FAIL watchdog global timeout actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [NB*8-1:0] p9;
        rst_n = 0; start = 0; cmd_ready = 0; rd_valid = 0; rd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !pass && !cmd_valid, "R1 flags after reset",
            NB*8'({busy, done, pass, cmd_valid}), 0);
        chk(err_count == 0 && !first_err_valid, "R1 record after reset",
            NB*8'({first_err_valid, err_count}), 0);

        // clean sweep, with a start pulse while busy (R2)
        fault_en = 0;
        push_run();
        pulse_start();
        chk(busy, "R2 start begins sweep", NB*8'(busy), 1);
        repeat (300) @(negedge clk);
        pulse_start();
        wait_done();
        chk(q.size() == 0, "R2/R8 full command stream", NB*8'(q.size()), 0);
        chk(pass && err_count == 0 && !first_err_valid, "R11 clean pass",
            NB*8'({pass, first_err_valid, err_count}), NB*8'({1'b1, 1'b0, 16'd0}));
        repeat (5) @(negedge clk);
        chk(done && !cmd_valid, "R8/R11 done held, port quiet",
            NB*8'({done, cmd_valid}), NB*8'(2'b10));

        // sweep with injected faults (R9, R10)
        fault_en = 1;
        push_run();
        pulse_start();
        wait_done();
        p9 = exp_pat(9);
        chk(q.size() == 0, "R8 faulty sweep stream", NB*8'(q.size()), 0);
        chk(err_count == 3, "R9 mismatch count", NB*8'(err_count), 3);
        chk(!pass, "R11 fail flag", NB*8'(pass), 0);
        chk(first_err_valid && first_err_row == 9, "R10 first row",
            NB*8'(first_err_row), 9);
        chk(first_err_byte == 3, "R10 first lane", NB*8'(first_err_byte), 3);
        chk(first_err_exp == p9[3*8 +: 8], "R10 expected byte",
            NB*8'(first_err_exp), NB*8'(p9[3*8 +: 8]));
        chk(first_err_got == (p9[3*8 +: 8] ^ 8'h10), "R10 read byte",
            NB*8'(first_err_got), NB*8'(p9[3*8 +: 8] ^ 8'h10));

        // restart clears the record (R11)
        fault_en = 0;
        push_run();
        pulse_start();
        chk(err_count == 0 && !first_err_valid && !done, "R11 restart clears",
            NB*8'({done, first_err_valid, err_count}), 0);
        wait_done();
        chk(pass && q.size() == 0, "R11 second clean pass",
            NB*8'({pass, q.size() == 0}), NB*8'(2'b11));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule